// File: doc/BRIEF.md
# Exception Entry Controller

This block is the trap-entry stage of a 32-bit in-order processor. The pipeline offers one fault at a time: what kind of fault it is, the program counter of the faulting instruction and the one after it, the offending virtual address, the translation tag fields and a coprocessor number. In the cycle the fault is accepted, the controller updates the machine-control registers. These are the mode word, the cause word, the return address, the register-set control word, the bad-address register, the translation tag register and the page-context register. It also redirects fetch to the handler as three consecutive instruction addresses.

The handler is picked from the vector base register and the state that held *before* entry. The exception-level bit chooses between the refill vector and the general vector for translation refills. The vectored-interrupt bit moves interrupts to their own offset. The boot-vector bit sends an overflow to a fixed boot-region address. If the faulting instruction sits in a branch delay slot, the return address is moved back one instruction and the cause word records the fact.

A small load port lets the surrounding logic preset any of the eight registers. The controller runs a three-state machine:
- ST_BOOT is entered on reset and is left for ST_IDLE after one cycle.
- ST_IDLE raises `flt_ready` and moves to ST_SETTLE when a fault is accepted.
- ST_SETTLE raises `redirect` for one cycle and then returns to ST_IDLE.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises (ST_BOOT), `flt_ready` is 0. Reset sets fetch to 0xBFC00000, 0xBFC00004 and 0xBFC00008, sets `mode_q` to only bit 29 (coprocessor-1 usable), sets `vbase_q` to the VBASE_RST parameter and clears the other registers. A load in ST_BOOT is ignored.
- R2: A fault is accepted on a clock edge where `flt_valid` and `flt_ready` are both 1. Registers show the update in the next cycle. In that next cycle `flt_ready` is 0 and `redirect` is 1, and one cycle later `flt_ready` is 1 again and `redirect` is 0.
- R3: The fault kinds on `flt_kind` and the code written to `cause_q[6:2]` are:

  | Kind | Fault | Code |
  |---|---|---|
  | 0 | interrupt | 0 |
  | 1 | translation modified | 1 |
  | 2 | refill load/fetch | 2 |
  | 3 | refill store | 3 |
  | 4 | address error load/fetch | 4 |
  | 5 | address error store | 5 |
  | 6 | invalid load/fetch | 2 |
  | 7 | invalid store | 3 |
  | 8 | syscall | 8 |
  | 9 | breakpoint | 9 |
  | 10 | reserved instruction | 10 |
  | 11 | coprocessor unusable | 11 |
  | 12 | overflow | 12 |
  | 13 | trap | 13 |
  | 14, 15 | same as reserved instruction | 10 |

- R4: Every accepted fault sets `mode_q[1]` (exception level), even when it is already 1.
- R5: The register-set control word holds the current set in bits 3:0, the previous set in bits 9:6 and the exception set in bits 15:12. If `mode_q[1]` and `mode_q[22]` were both 0 before entry, the previous set takes the old current set and the current set takes the exception set. Otherwise the word is unchanged.
- R6: If `flt_npc` differs from `flt_pc`+4, `retpc_q` becomes `flt_pc`−4 and `cause_q[31]` becomes 1. Otherwise `retpc_q` becomes `flt_pc` and `cause_q[31]` becomes 0.
- R7: `cause_q[29:28]` becomes `flt_cop` for kind 11 and 0 for all other kinds. `cause_q[23]` is kept.
- R8: Fetch becomes handler, handler+4 and handler+8. Unless R9 to R11 say otherwise, the handler is `vbase_q`+0x180.
- R9: For kinds 2 and 3, the handler is `vbase_q`+0x000 when `mode_q[1]` was 0 before entry and `vbase_q`+0x180 when it was 1. Kinds 6 and 7 always use +0x180.
- R10: An interrupt goes to `vbase_q`+0x200 when `cause_q[23]` is 1 and to `vbase_q`+0x180 when it is 0.
- R11: An overflow goes to 0xBFC00200 when `mode_q[22]` is 1, and to `vbase_q`+0x180 otherwise.
- R12: Kinds 1 to 7 load `badaddr_q` with `flt_vaddr`; all other kinds leave it unchanged. Kinds 1, 2, 3, 6 and 7 also update two registers:
  - `tag_q`: bits 31:13 from `flt_vpn2`, bits 12:11 from `flt_vpn2x` and bits 7:0 from `flt_asid`, with bits 10:8 kept.
  - `ctx_q`: bits 22:4 from `flt_vpn2`, with the other bits kept.
- R13: A load with `ld_en` writes `ld_data` to the register named by `ld_sel`: 0 mode, 1 cause, 2 return address, 3 set control, 4 bad address, 5 tag, 6 context, 7 vector base. A load in the same cycle as an accepted fault is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flt_valid | input | 1 | Fault offered |
| flt_ready | output | 1 | Controller can accept a fault |
| flt_kind | input | 4 | Fault kind (R3) |
| flt_pc | input | 32 | Address of the faulting instruction |
| flt_npc | input | 32 | Address of the next instruction |
| flt_vaddr | input | 32 | Offending virtual address |
| flt_asid | input | 8 | Address-space identifier |
| flt_vpn2 | input | 19 | Virtual page-pair number |
| flt_vpn2x | input | 2 | Virtual page-pair number extension |
| flt_cop | input | 2 | Coprocessor number |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Register to load (R13) |
| ld_data | input | 32 | Load data |
| mode_q | output | 32 | Mode word |
| cause_q | output | 32 | Cause word |
| retpc_q | output | 32 | Return address |
| setctl_q | output | 32 | Register-set control word |
| badaddr_q | output | 32 | Bad virtual address |
| tag_q | output | 32 | Translation tag |
| ctx_q | output | 32 | Page context |
| vbase_q | output | 32 | Vector base |
| fetch_pc | output | 32 | Redirected fetch address |
| fetch_npc | output | 32 | Redirected fetch address + 4 |
| fetch_nnpc | output | 32 | Redirected fetch address + 8 |
| redirect | output | 1 | Fetch redirect pulse (ST_SETTLE) |

## Verification
The bench overrides only VBASE_RST, setting it to 0x80001000, and keeps the boot addresses, the offsets and the 4-byte instruction size at their defaults. This makes a vector-base-relative handler easy to tell apart from the fixed boot-region addresses. The base has a zero low byte, so a missing or wrong 0x180 or 0x200 offset appears as a distinct value rather than an overlap. With the default 4-byte step, the delay-slot case (next PC not equal to PC+4) and the +4/+8 fetch triple are reached with plain directed addresses.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int REG_W   = 32;
    localparam int CODE_W  = 5;
    localparam int CE_W    = 2;
    localparam int SET_W   = 4;
    localparam int ASID_W  = 8;
    localparam int VPN2_W  = 19;
    localparam int VPN2X_W = 2;
    localparam int SEL_W   = 3;
    localparam int KIND_W  = 4;

    // Mode word bits
    localparam int MODE_EXL = 1;
    localparam int MODE_BEV = 22;
    localparam int MODE_CU1 = 29;

    // Cause word fields
    localparam int CAUSE_CODE_LO = 2;
    localparam int CAUSE_IV      = 23;
    localparam int CAUSE_CE_LO   = 28;
    localparam int CAUSE_BD      = 31;

    // Register-set control fields
    localparam int SET_CUR_LO  = 0;
    localparam int SET_PREV_LO = 6;
    localparam int SET_EXC_LO  = 12;

    // Translation tag and context fields
    localparam int TAG_ASID_LO  = 0;
    localparam int TAG_VPN2X_LO = 11;
    localparam int TAG_VPN2_LO  = 13;
    localparam int CTX_VPN2_LO  = 4;

    typedef enum logic [KIND_W-1:0] {
        K_IRQ       = 4'd0,
        K_TLB_MOD   = 4'd1,
        K_REFILL_LD = 4'd2,
        K_REFILL_ST = 4'd3,
        K_ADDR_LD   = 4'd4,
        K_ADDR_ST   = 4'd5,
        K_INVAL_LD  = 4'd6,
        K_INVAL_ST  = 4'd7,
        K_SYSCALL   = 4'd8,
        K_BREAK     = 4'd9,
        K_RESV      = 4'd10,
        K_COP       = 4'd11,
        K_OVF       = 4'd12,
        K_TRAP      = 4'd13,
        K_SPARE0    = 4'd14,
        K_SPARE1    = 4'd15
    } fault_kind_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_MODE    = 3'd0,
        SEL_CAUSE   = 3'd1,
        SEL_RETPC   = 3'd2,
        SEL_SETCTL  = 3'd3,
        SEL_BADADDR = 3'd4,
        SEL_TAG     = 3'd5,
        SEL_CTX     = 3'd6,
        SEL_VBASE   = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_IDLE   = 2'd1,
        ST_SETTLE = 2'd2
    } entry_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              load_addr;
        logic              load_tag;
        logic              refill;
        logic              use_cop;
        logic              irq;
        logic              ovf;
    } fault_attr_t;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_entry_pkg::*;
(
    input  fault_kind_e kind,
    output fault_attr_t attr
);

    always_comb begin
        attr = '0;
        unique case (kind)
            K_IRQ: begin
                attr.code = 5'd0;
                attr.irq  = 1'b1;
            end
            K_TLB_MOD: begin
                attr.code      = 5'd1;
                attr.load_addr = 1'b1;
                attr.load_tag  = 1'b1;
            end
            K_REFILL_LD: begin
                attr.code      = 5'd2;
                attr.load_addr = 1'b1;
                attr.load_tag  = 1'b1;
                attr.refill    = 1'b1;
            end
            K_REFILL_ST: begin
                attr.code      = 5'd3;
                attr.load_addr = 1'b1;
                attr.load_tag  = 1'b1;
                attr.refill    = 1'b1;
            end
            K_ADDR_LD: begin
                attr.code      = 5'd4;
                attr.load_addr = 1'b1;
            end
            K_ADDR_ST: begin
                attr.code      = 5'd5;
                attr.load_addr = 1'b1;
            end
            K_INVAL_LD: begin
                attr.code      = 5'd2;
                attr.load_addr = 1'b1;
                attr.load_tag  = 1'b1;
            end
            K_INVAL_ST: begin
                attr.code      = 5'd3;
                attr.load_addr = 1'b1;
                attr.load_tag  = 1'b1;
            end
            K_SYSCALL: attr.code = 5'd8;
            K_BREAK:   attr.code = 5'd9;
            K_COP: begin
                attr.code    = 5'd11;
                attr.use_cop = 1'b1;
            end
            K_OVF: begin
                attr.code = 5'd12;
                attr.ovf  = 1'b1;
            end
            K_TRAP:    attr.code = 5'd13;
            default:   attr.code = 5'd10;
        endcase
    end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_entry_pkg::*;
#(
    parameter logic [REG_W-1:0] OVF_BOOT_PC = 32'hBFC0_0200,
    parameter logic [REG_W-1:0] GEN_OFF     = 32'h0000_0180,
    parameter logic [REG_W-1:0] IRQ_OFF     = 32'h0000_0200,
    parameter logic [REG_W-1:0] REFILL_OFF  = 32'h0000_0000
) (
    input  fault_attr_t       attr,
    input  logic [REG_W-1:0]  vbase,
    input  logic              lvl_before,
    input  logic              boot_vec,
    input  logic              irq_vec_en,
    output logic [REG_W-1:0]  handler
);

    logic [REG_W-1:0] offset;

    always_comb begin
        if (attr.refill && !lvl_before) begin
            offset = REFILL_OFF;
        end else if (attr.irq && irq_vec_en) begin
            offset = IRQ_OFF;
        end else begin
            offset = GEN_OFF;
        end
        if (attr.ovf && boot_vec) begin
            handler = OVF_BOOT_PC;
        end else begin
            handler = vbase + offset;
        end
    end

endmodule

// File: rtl/exc_sysregs.sv
module exc_sysregs
    import exc_entry_pkg::*;
#(
    parameter logic [REG_W-1:0] VBASE_RST  = 32'h8000_0000,
    parameter logic [REG_W-1:0] BOOT_PC    = 32'hBFC0_0000,
    parameter int               INSN_BYTES = 4,
    parameter int               FETCH_N    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit,
    input  fault_attr_t               attr,
    input  logic [REG_W-1:0]          handler,
    input  logic [REG_W-1:0]          flt_pc,
    input  logic [REG_W-1:0]          flt_npc,
    input  logic [REG_W-1:0]          flt_vaddr,
    input  logic [ASID_W-1:0]         flt_asid,
    input  logic [VPN2_W-1:0]         flt_vpn2,
    input  logic [VPN2X_W-1:0]        flt_vpn2x,
    input  logic [CE_W-1:0]           flt_cop,
    input  logic                      ld_go,
    input  reg_sel_e                  ld_sel,
    input  logic [REG_W-1:0]          ld_data,
    output logic [REG_W-1:0]          mode_q,
    output logic [REG_W-1:0]          cause_q,
    output logic [REG_W-1:0]          retpc_q,
    output logic [REG_W-1:0]          setctl_q,
    output logic [REG_W-1:0]          badaddr_q,
    output logic [REG_W-1:0]          tag_q,
    output logic [REG_W-1:0]          ctx_q,
    output logic [REG_W-1:0]          vbase_q,
    output logic [FETCH_N-1:0][REG_W-1:0] fetch_q
);

    localparam logic [REG_W-1:0] STEP     = REG_W'(INSN_BYTES);
    localparam logic [REG_W-1:0] MODE_RST = REG_W'(1) << MODE_CU1;

    logic             in_slot;
    logic [REG_W-1:0] mode_nx, cause_nx, retpc_nx, setctl_nx;
    logic [REG_W-1:0] badaddr_nx, tag_nx, ctx_nx;

    assign in_slot = (flt_npc != (flt_pc + STEP));

    always_comb begin
        mode_nx           = mode_q;
        mode_nx[MODE_EXL] = 1'b1;

        cause_nx                              = cause_q;
        cause_nx[CAUSE_BD]                    = in_slot;
        cause_nx[CAUSE_CE_LO +: CE_W]         = attr.use_cop ? flt_cop : '0;
        cause_nx[CAUSE_CODE_LO +: CODE_W]     = attr.code;

        retpc_nx = in_slot ? (flt_pc - STEP) : flt_pc;

        setctl_nx = setctl_q;
        if (!mode_q[MODE_EXL] && !mode_q[MODE_BEV]) begin
            setctl_nx[SET_PREV_LO +: SET_W] = setctl_q[SET_CUR_LO +: SET_W];
            setctl_nx[SET_CUR_LO +: SET_W]  = setctl_q[SET_EXC_LO +: SET_W];
        end

        badaddr_nx = attr.load_addr ? flt_vaddr : badaddr_q;

        tag_nx = tag_q;
        ctx_nx = ctx_q;
        if (attr.load_tag) begin
            tag_nx[TAG_ASID_LO +: ASID_W]   = flt_asid;
            tag_nx[TAG_VPN2X_LO +: VPN2X_W] = flt_vpn2x;
            tag_nx[TAG_VPN2_LO +: VPN2_W]   = flt_vpn2;
            ctx_nx[CTX_VPN2_LO +: VPN2_W]   = flt_vpn2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_RST;
            cause_q   <= '0;
            retpc_q   <= '0;
            setctl_q  <= '0;
            badaddr_q <= '0;
            tag_q     <= '0;
            ctx_q     <= '0;
            vbase_q   <= VBASE_RST;
        end else if (commit) begin
            mode_q    <= mode_nx;
            cause_q   <= cause_nx;
            retpc_q   <= retpc_nx;
            setctl_q  <= setctl_nx;
            badaddr_q <= badaddr_nx;
            tag_q     <= tag_nx;
            ctx_q     <= ctx_nx;
        end else if (ld_go) begin
            unique case (ld_sel)
                SEL_MODE:    mode_q    <= ld_data;
                SEL_CAUSE:   cause_q   <= ld_data;
                SEL_RETPC:   retpc_q   <= ld_data;
                SEL_SETCTL:  setctl_q  <= ld_data;
                SEL_BADADDR: badaddr_q <= ld_data;
                SEL_TAG:     tag_q     <= ld_data;
                SEL_CTX:     ctx_q     <= ld_data;
                SEL_VBASE:   vbase_q   <= ld_data;
                default:     vbase_q   <= vbase_q;
            endcase
        end
    end

    // One register per redirected fetch slot, each a fixed step apart.
    for (genvar gi = 0; gi < FETCH_N; gi++) begin : g_fetch
        localparam logic [REG_W-1:0] SLOT_OFF = REG_W'(gi * INSN_BYTES);
        logic [REG_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= BOOT_PC + SLOT_OFF;
            end else if (commit) begin
                slot_q <= handler + SLOT_OFF;
            end
        end
        assign fetch_q[gi] = slot_q;
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter logic [31:0] VBASE_RST   = 32'h8000_0000,
    parameter logic [31:0] BOOT_PC     = 32'hBFC0_0000,
    parameter logic [31:0] OVF_BOOT_PC = 32'hBFC0_0200,
    parameter logic [31:0] GEN_OFF     = 32'h0000_0180,
    parameter logic [31:0] IRQ_OFF     = 32'h0000_0200,
    parameter logic [31:0] REFILL_OFF  = 32'h0000_0000,
    parameter int          INSN_BYTES  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flt_valid,
    output logic        flt_ready,
    input  logic [3:0]  flt_kind,
    input  logic [31:0] flt_pc,
    input  logic [31:0] flt_npc,
    input  logic [31:0] flt_vaddr,
    input  logic [7:0]  flt_asid,
    input  logic [18:0] flt_vpn2,
    input  logic [1:0]  flt_vpn2x,
    input  logic [1:0]  flt_cop,
    input  logic        ld_en,
    input  logic [2:0]  ld_sel,
    input  logic [31:0] ld_data,
    output logic [31:0] mode_q,
    output logic [31:0] cause_q,
    output logic [31:0] retpc_q,
    output logic [31:0] setctl_q,
    output logic [31:0] badaddr_q,
    output logic [31:0] tag_q,
    output logic [31:0] ctx_q,
    output logic [31:0] vbase_q,
    output logic [31:0] fetch_pc,
    output logic [31:0] fetch_npc,
    output logic [31:0] fetch_nnpc,
    output logic        redirect
);

    localparam int FETCH_N = 3;

    entry_state_e state_q, state_nx;
    logic         accept;
    logic         ld_go;
    fault_attr_t  attr;
    logic [REG_W-1:0] handler;
    logic [FETCH_N-1:0][REG_W-1:0] fetch_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx  = state_q;
        flt_ready = 1'b0;
        redirect  = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                state_nx = ST_IDLE;
            end
            ST_IDLE: begin
                flt_ready = 1'b1;
                if (flt_valid) begin
                    state_nx = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                redirect = 1'b1;
                state_nx = ST_IDLE;
            end
            default: begin
                state_nx = ST_BOOT;
            end
        endcase
    end

    assign accept = flt_valid && flt_ready;
    assign ld_go  = ld_en && (state_q != ST_BOOT) && !accept;

    exc_classify u_classify (
        .kind (fault_kind_e'(flt_kind)),
        .attr (attr)
    );

    exc_vector_sel #(
        .OVF_BOOT_PC (OVF_BOOT_PC),
        .GEN_OFF     (GEN_OFF),
        .IRQ_OFF     (IRQ_OFF),
        .REFILL_OFF  (REFILL_OFF)
    ) u_vector (
        .attr       (attr),
        .vbase      (vbase_q),
        .lvl_before (mode_q[MODE_EXL]),
        .boot_vec   (mode_q[MODE_BEV]),
        .irq_vec_en (cause_q[CAUSE_IV]),
        .handler    (handler)
    );

    exc_sysregs #(
        .VBASE_RST  (VBASE_RST),
        .BOOT_PC    (BOOT_PC),
        .INSN_BYTES (INSN_BYTES),
        .FETCH_N    (FETCH_N)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (accept),
        .attr      (attr),
        .handler   (handler),
        .flt_pc    (flt_pc),
        .flt_npc   (flt_npc),
        .flt_vaddr (flt_vaddr),
        .flt_asid  (flt_asid),
        .flt_vpn2  (flt_vpn2),
        .flt_vpn2x (flt_vpn2x),
        .flt_cop   (flt_cop),
        .ld_go     (ld_go),
        .ld_sel    (reg_sel_e'(ld_sel)),
        .ld_data   (ld_data),
        .mode_q    (mode_q),
        .cause_q   (cause_q),
        .retpc_q   (retpc_q),
        .setctl_q  (setctl_q),
        .badaddr_q (badaddr_q),
        .tag_q     (tag_q),
        .ctx_q     (ctx_q),
        .vbase_q   (vbase_q),
        .fetch_q   (fetch_q)
    );

    assign fetch_pc   = fetch_q[0];
    assign fetch_npc  = fetch_q[1];
    assign fetch_nnpc = fetch_q[2];

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int INSN_BYTES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        flt_valid,
    input logic        flt_ready,
    input logic [3:0]  flt_kind,
    input logic [31:0] flt_pc,
    input logic [31:0] flt_npc,
    input logic [31:0] mode_q,
    input logic [31:0] cause_q,
    input logic [31:0] retpc_q,
    input logic [31:0] setctl_q,
    input logic [31:0] fetch_pc,
    input logic [31:0] fetch_npc,
    input logic [31:0] fetch_nnpc,
    input logic        redirect
);

    localparam logic [31:0] STEP = 32'(INSN_BYTES);

    logic acc;
    assign acc = flt_valid && flt_ready;

    a_r2_settle_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (!flt_ready && redirect));

    a_r2_redirect_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> $past(acc));

    a_r4_level_set: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> mode_q[1]);

    a_r5_sets_held: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (mode_q[1] || mode_q[22])) |=> $stable(setctl_q));

    a_r6_plain_return: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (flt_npc == flt_pc + STEP)) |=> (!cause_q[31] && retpc_q == $past(flt_pc)));

    a_r6_slot_return: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (flt_npc != flt_pc + STEP)) |=> (cause_q[31] && retpc_q == $past(flt_pc) - STEP));

    a_r7_cop_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && flt_kind != 4'd11) |=> (cause_q[29:28] == 2'd0));

    a_r8_fetch_triple: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (fetch_npc == fetch_pc + STEP && fetch_nnpc == fetch_pc + 2 * STEP));

endmodule

bind exc_entry_ctrl exc_entry_chk #(.INSN_BYTES(INSN_BYTES)) u_exc_entry_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flt_valid  (flt_valid),
    .flt_ready  (flt_ready),
    .flt_kind   (flt_kind),
    .flt_pc     (flt_pc),
    .flt_npc    (flt_npc),
    .mode_q     (mode_q),
    .cause_q    (cause_q),
    .retpc_q    (retpc_q),
    .setctl_q   (setctl_q),
    .fetch_pc   (fetch_pc),
    .fetch_npc  (fetch_npc),
    .fetch_nnpc (fetch_nnpc),
    .redirect   (redirect)
);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;

    localparam logic [31:0] VB   = 32'h8000_1000;
    localparam logic [31:0] CU1  = 32'h2000_0000;
    localparam logic [31:0] BEVB = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_valid = 1'b0;
    logic        flt_ready;
    logic [3:0]  flt_kind = '0;
    logic [31:0] flt_pc = '0, flt_npc = '0, flt_vaddr = '0;
    logic [7:0]  flt_asid = '0;
    logic [18:0] flt_vpn2 = '0;
    logic [1:0]  flt_vpn2x = '0, flt_cop = '0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] mode_q, cause_q, retpc_q, setctl_q, badaddr_q, tag_q, ctx_q, vbase_q;
    logic [31:0] fetch_pc, fetch_npc, fetch_nnpc;
    logic        redirect;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    exc_entry_ctrl #(.VBASE_RST(VB)) i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_ready(flt_ready),
        .flt_kind(flt_kind), .flt_pc(flt_pc), .flt_npc(flt_npc), .flt_vaddr(flt_vaddr),
        .flt_asid(flt_asid), .flt_vpn2(flt_vpn2), .flt_vpn2x(flt_vpn2x), .flt_cop(flt_cop),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .mode_q(mode_q), .cause_q(cause_q), .retpc_q(retpc_q), .setctl_q(setctl_q),
        .badaddr_q(badaddr_q), .tag_q(tag_q), .ctx_q(ctx_q), .vbase_q(vbase_q),
        .fetch_pc(fetch_pc), .fetch_npc(fetch_npc), .fetch_nnpc(fetch_nnpc),
        .redirect(redirect)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_data = data;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Offer a fault; returns at the negedge after acceptance.
    task automatic fire(input logic [3:0] k, input logic [31:0] pc, input logic [31:0] npc,
                        input logic [31:0] va, input logic [7:0] asid, input logic [18:0] vpn2,
                        input logic [1:0] vpn2x, input logic [1:0] cop);
        @(negedge clk);
        while (!flt_ready) @(negedge clk);
        flt_valid = 1'b1; flt_kind = k; flt_pc = pc; flt_npc = npc; flt_vaddr = va;
        flt_asid = asid; flt_vpn2 = vpn2; flt_vpn2x = vpn2x; flt_cop = cop;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    task automatic fire_simple(input logic [3:0] k);
        fire(k, 32'h0000_0400, 32'h0000_0404, 32'h0BAD_0BAD, 8'h11, 19'h01111, 2'd1, 2'd3);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 ready low in reset", {31'd0, flt_ready}, 32'd0);
        rst_n = 1'b1;
        ld_en = 1'b1; ld_sel = 3'd7; ld_data = 32'h7000_0000;   // load during ST_BOOT
        chk("R1 ready low in boot", {31'd0, flt_ready}, 32'd0);
        chk("R1 boot pc", fetch_pc, 32'hBFC0_0000);
        chk("R1 boot npc", fetch_npc, 32'hBFC0_0004);
        chk("R1 boot nnpc", fetch_nnpc, 32'hBFC0_0008);
        chk("R1 mode reset", mode_q, CU1);
        chk("R1 cause reset", cause_q, 32'd0);
        chk("R1 setctl reset", setctl_q, 32'd0);
        @(negedge clk);
        ld_en = 1'b0;
        chk("R1 boot load ignored", vbase_q, VB);
        chk("R2 ready after boot", {31'd0, flt_ready}, 32'd1);
    endtask

    task automatic t_syscall_swap;
        load(3'd3, 32'h0000_3001);
        fire_simple(4'd8);
        chk("R2 ready low after accept", {31'd0, flt_ready}, 32'd0);
        chk("R2 redirect pulse", {31'd0, redirect}, 32'd1);
        chk("R3 syscall code", {27'd0, cause_q[6:2]}, 32'd8);
        chk("R4 level set", {31'd0, mode_q[1]}, 32'd1);
        chk("R5 set swap", setctl_q, 32'h0000_3043);
        chk("R6 no slot return", retpc_q, 32'h0000_0400);
        chk("R6 no slot flag", {31'd0, cause_q[31]}, 32'd0);
        chk("R8 handler", fetch_pc, VB + 32'h180);
        chk("R8 handler+4", fetch_npc, VB + 32'h184);
        chk("R8 handler+8", fetch_nnpc, VB + 32'h188);
        @(negedge clk);
        chk("R2 ready back", {31'd0, flt_ready}, 32'd1);
        chk("R2 redirect ends", {31'd0, redirect}, 32'd0);
    endtask

    task automatic t_slot_nested;
        fire(4'd9, 32'h0000_1000, 32'h0000_2000, 32'h0, 8'h0, 19'h0, 2'd0, 2'd0);
        chk("R6 slot return", retpc_q, 32'h0000_0FFC);
        chk("R6 slot flag", {31'd0, cause_q[31]}, 32'd1);
        chk("R3 break code", {27'd0, cause_q[6:2]}, 32'd9);
        chk("R5 sets held with level set", setctl_q, 32'h0000_3043);
        chk("R4 level stays set", {31'd0, mode_q[1]}, 32'd1);
    endtask

    task automatic t_refill;
        logic [31:0] exp_tag;
        fire(4'd2, 32'h400, 32'h404, 32'hDEAD_0000, 8'h5A, 19'h12345, 2'd1, 2'd0);
        chk("R9 refill with level set", fetch_pc, VB + 32'h180);
        chk("R3 refill load code", {27'd0, cause_q[6:2]}, 32'd2);
        chk("R12 bad address", badaddr_q, 32'hDEAD_0000);
        exp_tag = (32'h12345 << 13) | (32'd1 << 11) | 32'h5A;
        chk("R12 tag", tag_q, exp_tag);
        load(3'd0, CU1);
        load(3'd6, 32'hFFFF_FFFF);
        load(3'd5, 32'h0000_0700);
        fire(4'd3, 32'h400, 32'h404, 32'h00C0_FFEE, 8'h33, 19'h0F0F0, 2'd2, 2'd0);
        chk("R9 refill with level clear", fetch_pc, VB);
        chk("R3 refill store code", {27'd0, cause_q[6:2]}, 32'd3);
        chk("R12 context", ctx_q, 32'hFF80_000F | (32'h0F0F0 << 4));
        exp_tag = (32'h0F0F0 << 13) | (32'd2 << 11) | 32'h700 | 32'h33;
        chk("R12 tag keeps bits 10:8", tag_q, exp_tag);
    endtask

    task automatic t_irq;
        load(3'd0, CU1);
        load(3'd1, 32'h0080_0000);
        fire_simple(4'd0);
        chk("R10 vectored interrupt", fetch_pc, VB + 32'h200);
        chk("R3 interrupt code", {27'd0, cause_q[6:2]}, 32'd0);
        chk("R7 vector bit kept", {31'd0, cause_q[23]}, 32'd1);
        load(3'd0, CU1);
        load(3'd1, 32'd0);
        fire_simple(4'd0);
        chk("R10 plain interrupt", fetch_pc, VB + 32'h180);
    endtask

    task automatic t_ovf;
        load(3'd3, 32'h0000_3043);
        load(3'd0, CU1 | BEVB);
        fire_simple(4'd12);
        chk("R11 overflow boot vector", fetch_pc, 32'hBFC0_0200);
        chk("R11 overflow boot +8", fetch_nnpc, 32'hBFC0_0208);
        chk("R3 overflow code", {27'd0, cause_q[6:2]}, 32'd12);
        chk("R5 sets held with boot bit", setctl_q, 32'h0000_3043);
        load(3'd0, CU1);
        fire_simple(4'd12);
        chk("R11 overflow normal vector", fetch_pc, VB + 32'h180);
    endtask

    task automatic t_cop;
        fire(4'd11, 32'h400, 32'h404, 32'h0, 8'h0, 19'h0, 2'd0, 2'd2);
        chk("R7 coprocessor id", {30'd0, cause_q[29:28]}, 32'd2);
        chk("R3 coprocessor code", {27'd0, cause_q[6:2]}, 32'd11);
        fire_simple(4'd8);
        chk("R7 id cleared", {30'd0, cause_q[29:28]}, 32'd0);
    endtask

    task automatic t_addr;
        logic [31:0] tag_before;
        tag_before = tag_q;
        fire(4'd5, 32'h400, 32'h404, 32'h1234_5677, 8'hEE, 19'h7FFFF, 2'd3, 2'd0);
        chk("R12 address error loads bad address", badaddr_q, 32'h1234_5677);
        chk("R12 address error keeps tag", tag_q, tag_before);
        chk("R3 address store code", {27'd0, cause_q[6:2]}, 32'd5);
        fire(4'd13, 32'h400, 32'h404, 32'h0000_9999, 8'h0, 19'h0, 2'd0, 2'd0);
        chk("R12 trap keeps bad address", badaddr_q, 32'h1234_5677);
        chk("R3 trap code", {27'd0, cause_q[6:2]}, 32'd13);
    endtask

    task automatic t_codes;
        logic [3:0] kinds [7] = '{4'd1, 4'd4, 4'd6, 4'd7, 4'd10, 4'd14, 4'd15};
        logic [4:0] codes [7] = '{5'd1, 5'd4, 5'd2, 5'd3, 5'd10, 5'd10, 5'd10};
        for (int i = 0; i < 7; i++) begin
            load(3'd0, CU1);
            fire_simple(kinds[i]);
            chk($sformatf("R3 code for kind %0d", kinds[i]), {27'd0, cause_q[6:2]}, {27'd0, codes[i]});
            chk($sformatf("R9 general vector for kind %0d", kinds[i]), fetch_pc, VB + 32'h180);
        end
    endtask

    task automatic t_collision;
        @(negedge clk);
        while (!flt_ready) @(negedge clk);
        flt_valid = 1'b1; flt_kind = 4'd8; flt_pc = 32'h400; flt_npc = 32'h404;
        ld_en = 1'b1; ld_sel = 3'd7; ld_data = 32'h9000_0000;
        @(negedge clk);
        flt_valid = 1'b0; ld_en = 1'b0;
        chk("R13 load dropped on accept", vbase_q, VB);
        chk("R13 fault still taken", fetch_pc, VB + 32'h180);
        load(3'd7, 32'h9000_0000);
        chk("R13 load applied", vbase_q, 32'h9000_0000);
        fire_simple(4'd8);
        chk("R13 new base used", fetch_pc, 32'h9000_0180);
    endtask

    initial begin
        t_reset();
        t_syscall_swap();
        t_slot_nested();
        t_refill();
        t_irq();
        t_ovf();
        t_cop();
        t_addr();
        t_codes();
        t_collision();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule